// File: doc/BRIEF.md
# Sensor Scratchpad with Shadowed Settings and CRC

This block holds the nine-byte working register file of a digital temperature sensor endpoint. A bus front end, which handles bus reset, presence and ROM matching elsewhere, passes in a decoded function command together with single data bits and read-slot requests. The block answers with one data bit per read slot. Bytes 0 and 1 hold the latest temperature word, which a conversion unit supplies. Bytes 2 and 3 are the upper and lower alarm thresholds. Byte 4 is the configuration byte, and only its two resolution bits can be written. Bytes 5 to 7 are fixed. Byte 8 is a CRC derived continuously from bytes 0 to 7.

Bytes 2 to 4 are backed by a three-byte shadow store that stands in for nonvolatile memory. A copy command saves them, taking a set number of cycles to do so. A recall command restores them, and it reports progress through read slots, which return 0 while the recall runs and 1 once it is finished. All data moves least significant bit first.

Top module: `sensor_scratchpad`

## Requirements
- R1: After reset, a full read returns the bytes 50h, 05h, 4Bh, 46h, 7Fh, FFh, 0Ch, 10h, 1Ch in the order byte 0 to byte 8, rd_ack is 0 and rd_bit is 1.
- R2: Command BEh starts a read at bit 0 of byte 0. Each rd_slot shifts out one bit, least significant bit first, byte 0 up to byte 8. The bit appears on rd_bit, with rd_ack high, one cycle after the slot. Slots after the 72nd bit return 1.
- R3: Command 4Eh accepts wr_bit bits, least significant bit first, into byte 2, then byte 3, then byte 4. Bytes 0, 1 and 5 to 7 never change as a result.
- R4: In byte 4, only bits 6..5 (the resolution field) take written values. Bit 7 always reads 0 and bits 4..0 always read 1.
- R5: A byte is updated only when its eighth bit arrives. A write that is cut short leaves the incomplete byte and every later byte unchanged. Bits after the 24th are ignored.
- R6: Byte 8 equals the CRC-8 of bytes 0..7 taken least significant bit first, using the reflected polynomial x^8+x^5+x^4+1 (8Ch) with an initial value of 0. It tracks every change to those bytes.
- R7: A cycle with temp_valid high loads temp_word into bytes 0 (low half) and 1 (high half).
- R8: Command 48h stores bytes 2 to 4 in the shadow store. A later recall brings back those saved values.
- R9: Command B8h sets bytes 2 to 4 from the shadow store. Exactly RD_CYCLES read slots after the command return 0, and the slots after that return 1.
- R10: Holding abort high for one cycle ends a read. Slots in the idle state then return 1, and the next BEh starts again at byte 0.
- R11: While a copy or recall is running, commands are ignored, so write bits cannot change the scratchpad.
- R12: An accepted command ends any read or write in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded function command |
| cmd_code | input | 8 | Command byte: 4Eh write, BEh read, 48h copy, B8h recall |
| abort | input | 1 | Ends the current transfer and returns to idle |
| wr_bit_valid | input | 1 | A write data bit is present |
| wr_bit | input | 1 | Write data bit |
| rd_slot | input | 1 | Read slot request |
| rd_bit | output | 1 | Bit answering the previous read slot |
| rd_ack | output | 1 | High for one cycle when rd_bit carries a slot answer |
| temp_valid | input | 1 | Loads a new temperature word |
| temp_word | input | 16 | Temperature from the conversion unit |

## Verification
A wrong byte pointer or a misplaced commit shows up on the next full read. A value lands in the wrong byte, and the CRC byte, nine bytes further on, disagrees as well. A faulty shadow counter or op flag shows up during a recall, because the run of zero slots comes out longer or shorter than RD_CYCLES. It also shows up on the read-back right after the recall. A bad mode transition, such as one taken during a busy period or after an abort, becomes visible at the very next slot or write bit.

// File: rtl/spad_pkg.sv
// Shared definitions for the sensor scratchpad: command codes, the
// transfer mode type and a single-bit CRC-8 step (reflected 8Ch form).
package spad_pkg;

    localparam logic [7:0] CMD_WRITE_SP  = 8'h4E;
    localparam logic [7:0] CMD_READ_SP   = 8'hBE;
    localparam logic [7:0] CMD_COPY_SP   = 8'h48;
    localparam logic [7:0] CMD_RECALL_NV = 8'hB8;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_READ  = 2'd2,
        MODE_NVM   = 2'd3
    } spad_mode_e;

    // Advance the CRC register by one data bit (LSB-first, reflected poly).
    function automatic logic [7:0] crc8_bit(input logic [7:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return {1'b0, c[7:1]} ^ (fb ? 8'h8C : 8'h00);
    endfunction

endpackage

// File: rtl/spad_crc8.sv
// Combinational CRC-8 over NBYTES bytes, bit 0 of the vector first.
// Assumes the vector is the little-endian byte image of the scratchpad.
module spad_crc8 #(
    parameter int NBYTES = 8
) (
    input  logic [NBYTES*8-1:0] data,
    output logic [7:0]          crc
);
    import spad_pkg::*;

    localparam int NBITS = NBYTES * 8;

    logic [7:0] chain [0:NBITS];

    assign chain[0] = 8'h00;

    // One CRC step per data bit, chained in transmit order.
    for (genvar g = 0; g < NBITS; g++) begin : g_step
        assign chain[g+1] = crc8_bit(chain[g], data[g]);
    end

    assign crc = chain[NBITS];

endmodule

// File: rtl/spad_nv_shadow.sv
// Shadow store for the settings bytes, modelling nonvolatile memory.
// A copy latches wdata and commits it after WR_CYCLES cycles; a recall
// pulses recall_done after RD_CYCLES cycles, with rdata holding the
// stored bytes. Starts are ignored while busy. Assumes both delays >= 1.
module spad_nv_shadow #(
    parameter int                    NV_BYTES  = 3,
    parameter int                    WR_CYCLES = 40,
    parameter int                    RD_CYCLES = 20,
    parameter logic [NV_BYTES*8-1:0] INIT      = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_copy,
    input  logic                  start_recall,
    input  logic [NV_BYTES*8-1:0] wdata,
    output logic                  busy,
    output logic                  recall_done,
    output logic [NV_BYTES*8-1:0] rdata
);
    localparam int MAXC = (WR_CYCLES > RD_CYCLES) ? WR_CYCLES : RD_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic [7:0]            mem_q [NV_BYTES];
    logic [NV_BYTES*8-1:0] stage_q;
    logic [CW-1:0]         cnt_q;
    logic                  busy_q;
    logic                  op_recall_q;
    logic                  done_q;

    // Operation sequencer: delay count, staging and final commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            op_recall_q <= 1'b0;
            done_q      <= 1'b0;
            cnt_q       <= '0;
            stage_q     <= '0;
            for (int i = 0; i < NV_BYTES; i++) mem_q[i] <= INIT[8*i +: 8];
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    if (op_recall_q) begin
                        done_q <= 1'b1;
                    end else begin
                        for (int i = 0; i < NV_BYTES; i++) mem_q[i] <= stage_q[8*i +: 8];
                    end
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                end
            end else if (start_copy) begin
                busy_q      <= 1'b1;
                op_recall_q <= 1'b0;
                cnt_q       <= CW'(WR_CYCLES);
                stage_q     <= wdata;
            end else if (start_recall) begin
                busy_q      <= 1'b1;
                op_recall_q <= 1'b1;
                cnt_q       <= CW'(RD_CYCLES);
            end
        end
    end

    // Flatten the stored bytes for the reader.
    for (genvar g = 0; g < NV_BYTES; g++) begin : g_rd
        assign rdata[8*g +: 8] = mem_q[g];
    end

    assign busy        = busy_q;
    assign recall_done = done_q;

endmodule

// File: rtl/spad_serial_ctl.sv
// Transfer controller: accepts decoded commands, tracks the bit position
// of a read or write, assembles LSB-first write bytes and emits a commit
// strobe per completed byte. Commands are refused while the shadow is busy.
module spad_serial_ctl #(
    parameter int WR_BITS = 24,
    parameter int RD_BITS = 72
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic [7:0]                   cmd_code,
    input  logic                         nv_busy,
    input  logic                         abort,
    input  logic                         wr_bit_valid,
    input  logic                         wr_bit,
    input  logic                         rd_slot,
    output spad_pkg::spad_mode_e         mode,
    output logic [$clog2(RD_BITS+1)-1:0] bit_idx,
    output logic                         start_copy,
    output logic                         start_recall,
    output logic                         commit_valid,
    output logic [1:0]                   commit_sel,
    output logic [7:0]                   commit_byte
);
    import spad_pkg::*;

    localparam int CNT_W = $clog2(RD_BITS + 1);

    spad_mode_e       mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       shift_q;
    logic             cmd_accept;

    assign cmd_accept   = cmd_valid && !nv_busy;
    assign start_copy   = cmd_accept && (cmd_code == CMD_COPY_SP);
    assign start_recall = cmd_accept && (cmd_code == CMD_RECALL_NV);

    // Byte completes on its eighth bit, only inside the writable window.
    assign commit_valid = (mode_q == MODE_WRITE) && wr_bit_valid &&
                          (cnt_q < CNT_W'(WR_BITS)) && (cnt_q[2:0] == 3'd7);
    assign commit_byte  = {wr_bit, shift_q[7:1]};
    assign commit_sel   = cnt_q[4:3];

    // Mode, bit counter and write shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (cmd_accept) begin
            cnt_q   <= '0;
            shift_q <= '0;
            case (cmd_code)
                CMD_WRITE_SP:               mode_q <= MODE_WRITE;
                CMD_READ_SP:                mode_q <= MODE_READ;
                CMD_COPY_SP, CMD_RECALL_NV: mode_q <= MODE_NVM;
                default:                    mode_q <= MODE_IDLE;
            endcase
        end else if (abort) begin
            mode_q <= MODE_IDLE;
        end else begin
            case (mode_q)
                MODE_WRITE: if (wr_bit_valid) begin
                    shift_q <= {wr_bit, shift_q[7:1]};
                    if (cnt_q < CNT_W'(WR_BITS)) cnt_q <= cnt_q + CNT_W'(1);
                end
                MODE_READ: if (rd_slot && (cnt_q < CNT_W'(RD_BITS))) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    assign mode    = mode_q;
    assign bit_idx = cnt_q;

endmodule

// File: rtl/sensor_scratchpad.sv
// Nine-byte sensor scratchpad: temperature (bytes 0-1), thresholds
// (2-3), configuration (4, resolution field only), fixed bytes 5-7 and
// a derived CRC in byte 8. Bytes 2-4 are shadowed in spad_nv_shadow.
// Assumes the bus front end delivers decoded commands and bit strobes.
module sensor_scratchpad #(
    parameter int          WR_CYCLES = 40,
    parameter int          RD_CYCLES = 20,
    parameter logic [15:0] TEMP_INIT = 16'h0550,
    parameter logic [7:0]  TH_INIT   = 8'h4B,
    parameter logic [7:0]  TL_INIT   = 8'h46,
    parameter logic [1:0]  RES_INIT  = 2'b11,
    parameter logic [7:0]  RSV5      = 8'hFF,
    parameter logic [7:0]  RSV6      = 8'h0C,
    parameter logic [7:0]  RSV7      = 8'h10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [7:0]  cmd_code,
    input  logic        abort,
    input  logic        wr_bit_valid,
    input  logic        wr_bit,
    input  logic        rd_slot,
    output logic        rd_bit,
    output logic        rd_ack,
    input  logic        temp_valid,
    input  logic [15:0] temp_word
);
    import spad_pkg::*;

    localparam int SP_BYTES = 9;
    localparam int RD_BITS  = SP_BYTES * 8;
    localparam int WR_BITS  = 24;
    localparam int CNT_W    = $clog2(RD_BITS + 1);
    localparam int NV_BYTES = WR_BITS / 8;

    function automatic logic [7:0] cfg_image(input logic [1:0] res);
        return {1'b0, res, 5'h1F};
    endfunction

    localparam logic [NV_BYTES*8-1:0] NV_INIT = {cfg_image(RES_INIT), TL_INIT, TH_INIT};

    spad_mode_e            mode;
    logic [CNT_W-1:0]      bit_idx;
    logic                  start_copy, start_recall;
    logic                  commit_valid;
    logic [1:0]            commit_sel;
    logic [7:0]            commit_byte;
    logic                  nv_busy, recall_done;
    logic [NV_BYTES*8-1:0] nv_rdata;

    logic [15:0]           temp_q;
    logic [7:0]            th_q, tl_q;
    logic [1:0]            res_q;
    logic [7:0]            crc_byte;
    logic [RD_BITS-1:0]    spad_flat;
    logic                  rd_bit_q, rd_ack_q;
    logic                  unused_nv_bits;

    spad_serial_ctl #(
        .WR_BITS (WR_BITS),
        .RD_BITS (RD_BITS)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code),
        .nv_busy      (nv_busy),
        .abort        (abort),
        .wr_bit_valid (wr_bit_valid),
        .wr_bit       (wr_bit),
        .rd_slot      (rd_slot),
        .mode         (mode),
        .bit_idx      (bit_idx),
        .start_copy   (start_copy),
        .start_recall (start_recall),
        .commit_valid (commit_valid),
        .commit_sel   (commit_sel),
        .commit_byte  (commit_byte)
    );

    spad_nv_shadow #(
        .NV_BYTES  (NV_BYTES),
        .WR_CYCLES (WR_CYCLES),
        .RD_CYCLES (RD_CYCLES),
        .INIT      (NV_INIT)
    ) u_nv (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_copy   (start_copy),
        .start_recall (start_recall),
        .wdata        ({cfg_image(res_q), tl_q, th_q}),
        .busy         (nv_busy),
        .recall_done  (recall_done),
        .rdata        (nv_rdata)
    );

    // Fixed config bits are rebuilt on recall, so their stored copy is dropped.
    assign unused_nv_bits = ^{nv_rdata[23], nv_rdata[20:16]};

    // Temperature bytes follow the conversion unit.
    always_ff @(posedge clk) begin
        if (!rst_n)          temp_q <= TEMP_INIT;
        else if (temp_valid) temp_q <= temp_word;
    end

    // Settings bytes: recall has priority over serial commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            th_q  <= TH_INIT;
            tl_q  <= TL_INIT;
            res_q <= RES_INIT;
        end else if (recall_done) begin
            th_q  <= nv_rdata[7:0];
            tl_q  <= nv_rdata[15:8];
            res_q <= nv_rdata[22:21];
        end else if (commit_valid) begin
            case (commit_sel)
                2'd0:    th_q  <= commit_byte;
                2'd1:    tl_q  <= commit_byte;
                2'd2:    res_q <= commit_byte[6:5];
                default: ;
            endcase
        end
    end

    spad_crc8 #(.NBYTES(8)) u_crc (
        .data (spad_flat[63:0]),
        .crc  (crc_byte)
    );

    assign spad_flat = {crc_byte, RSV7, RSV6, RSV5, cfg_image(res_q), tl_q, th_q, temp_q};

    // Answer each read slot one cycle later: data, recall status or idle-high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bit_q <= 1'b1;
            rd_ack_q <= 1'b0;
        end else begin
            rd_ack_q <= rd_slot;
            if (rd_slot) begin
                case (mode)
                    MODE_READ: rd_bit_q <= (bit_idx < CNT_W'(RD_BITS)) ? spad_flat[bit_idx] : 1'b1;
                    MODE_NVM:  rd_bit_q <= !nv_busy;
                    default:   rd_bit_q <= 1'b1;
                endcase
            end
        end
    end

    assign rd_bit = rd_bit_q;
    assign rd_ack = rd_ack_q;

endmodule

// File: rtl/sensor_scratchpad_chk.sv
// Property checker for sensor_scratchpad, attached by bind below.
module sensor_scratchpad_chk #(
    parameter int CNT_W   = 7,
    parameter int RD_BITS = 72
) (
    input logic                 clk,
    input logic                 rst_n,
    input spad_pkg::spad_mode_e mode,
    input logic [CNT_W-1:0]     bit_idx,
    input logic                 rd_slot,
    input logic                 rd_bit,
    input logic                 nv_busy,
    input logic                 recall_done,
    input logic                 cmd_valid,
    input logic                 abort,
    input logic                 temp_valid,
    input logic [15:0]          temp_q,
    input logic                 wr_bit_valid,
    input logic [7:0]           th_q,
    input logic [7:0]           tl_q,
    input logic [1:0]           res_q
);
    import spad_pkg::*;

    // R2
    past_end_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_READ && rd_slot && bit_idx >= CNT_W'(RD_BITS)) |=> rd_bit);

    // R9
    recall_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NVM && nv_busy && rd_slot) |=> !rd_bit);

    // R7
    temp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_valid |=> $stable(temp_q));

    // R11
    busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NVM && nv_busy && cmd_valid && !abort) |=> mode == MODE_NVM);

    // R5
    idle_bits_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bit_valid && mode == MODE_IDLE && !recall_done) |=> $stable({th_q, tl_q, res_q}));

endmodule

bind sensor_scratchpad sensor_scratchpad_chk #(
    .CNT_W   (CNT_W),
    .RD_BITS (RD_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .bit_idx      (bit_idx),
    .rd_slot      (rd_slot),
    .rd_bit       (rd_bit),
    .nv_busy      (nv_busy),
    .recall_done  (recall_done),
    .cmd_valid    (cmd_valid),
    .abort        (abort),
    .temp_valid   (temp_valid),
    .temp_q       (temp_q),
    .wr_bit_valid (wr_bit_valid),
    .th_q         (th_q),
    .tl_q         (tl_q),
    .res_q        (res_q)
);

// File: tb/sensor_scratchpad_bench.sv
`timescale 1ns/1ps
module sensor_scratchpad_bench;

    localparam int WRC = 40;
    localparam int RDC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic        abort = 1'b0;
    logic        wr_bit_valid = 1'b0;
    logic        wr_bit = 1'b0;
    logic        rd_slot = 1'b0;
    logic        rd_bit;
    logic        rd_ack;
    logic        temp_valid = 1'b0;
    logic [15:0] temp_word = 16'h0000;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state
    logic [15:0] m_temp = 16'h0550;
    logic [7:0]  m_th = 8'h4B, m_tl = 8'h46;
    logic [1:0]  m_res = 2'b11;
    logic [7:0]  nv_th = 8'h4B, nv_tl = 8'h46;
    logic [1:0]  nv_res = 2'b11;

    always #10 clk = ~clk;

    sensor_scratchpad #(.WR_CYCLES(WRC), .RD_CYCLES(RDC)) u_sensor_scratchpad (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .abort(abort), .wr_bit_valid(wr_bit_valid), .wr_bit(wr_bit),
        .rd_slot(rd_slot), .rd_bit(rd_bit), .rd_ack(rd_ack),
        .temp_valid(temp_valid), .temp_word(temp_word)
    );

    function automatic logic [7:0] ref_crc(input logic [63:0] img);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 64; i++) begin
            logic mix = c[0] ^ img[i];
            c = c >> 1;
            if (mix) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    function automatic logic [71:0] ref_image();
        logic [63:0] lo;
        lo = {8'h10, 8'h0C, 8'hFF, {1'b0, m_res, 5'h1F}, m_tl, m_th, m_temp};
        return {ref_crc(lo), lo};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] c);
        cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] d, input int n);
        for (int i = 0; i < n; i++) begin
            wr_bit_valid = 1'b1; wr_bit = d[i];
            @(negedge clk);
        end
        wr_bit_valid = 1'b0;
    endtask

    task automatic model_write(input logic [31:0] d, input int n);
        if (n >= 8)  m_th  = d[7:0];
        if (n >= 16) m_tl  = d[15:8];
        if (n >= 24) m_res = d[22:21];
    endtask

    task automatic read_bits(input int n, output logic [95:0] got);
        got = '1;
        for (int i = 0; i < n; i++) begin
            rd_slot = 1'b1;
            @(negedge clk);
            got[i] = rd_bit;
        end
        rd_slot = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Full read of all nine bytes compared with the reference image.
    task automatic check_all(input string tag);
        logic [95:0] got;
        logic [71:0] exp;
        exp = ref_image();
        send_cmd(8'hBE);
        read_bits(72, got);
        for (int k = 0; k < 9; k++) check(tag, {24'h0, got[8*k +: 8]}, {24'h0, exp[8*k +: 8]});
    endtask

    task automatic load_temp(input logic [15:0] v);
        temp_valid = 1'b1; temp_word = v;
        @(negedge clk);
        temp_valid = 1'b0;
        m_temp = v;
    endtask

    // Recall with progress polling: exactly RDC zero slots expected.
    task automatic recall_and_check();
        logic [95:0] got;
        int zeros;
        send_cmd(8'hB8);
        read_bits(RDC + 4, got);
        zeros = 0;
        for (int i = 0; i < RDC + 4; i++) begin
            if (got[i] == 1'b0 && zeros == i) zeros++;
        end
        check("R9 recall zero slots", zeros, RDC);
        check("R9 slot after recall", {31'h0, got[RDC + 3]}, 32'h1);
        m_th = nv_th; m_tl = nv_tl; m_res = nv_res;
        check_all("R9 R8 data after recall");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [95:0] got;
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset outputs and power-up image, R6 known CRC value 1Ch
        check("R1 rd_ack after reset", {31'h0, rd_ack}, 32'h0);
        check("R1 rd_bit after reset", {31'h0, rd_bit}, 32'h1);
        check_all("R1 power-up image");
        send_cmd(8'hBE);
        read_bits(72, got);
        check("R6 power-up crc", {24'h0, got[71:64]}, 32'h1C);

        // R2 slots past the last byte return 1
        send_cmd(8'hBE);
        read_bits(80, got);
        check("R2 bits past byte 8", {24'h0, got[79:72]}, 32'hFF);
        check("R2 first byte lsb first", {24'h0, got[7:0]}, 32'h50);

        // R3 R4 full write; fixed bytes untouched, only resolution bits stick
        send_cmd(8'h4E); send_bits(32'h00FF55AA, 24); model_write(32'h00FF55AA, 24);
        check_all("R3 full write");
        send_cmd(8'h4E); send_bits(32'h00C012_34, 24); model_write(32'h00C01234, 24);
        check_all("R4 config mask 80h in");
        send_cmd(8'h4E); send_bits(32'h00200000, 24); model_write(32'h00200000, 24);
        check_all("R4 config res 01");

        // R5 partial write then over-long write
        send_cmd(8'h4E); send_bits(32'h00000A77, 12); model_write(32'h00000A77, 12);
        check_all("R5 partial write");
        send_cmd(8'h4E); send_bits(32'hFF6E5D4C, 32); model_write(32'hFF6E5D4C, 32);
        check_all("R5 bits after 24 ignored");

        // R7 R6 temperature load and CRC tracking
        load_temp(16'hFE6F);
        check_all("R7 R6 negative temperature");
        load_temp(16'h0191);
        check_all("R7 R6 positive temperature");

        // R10 abort ends a read, idle slots high, restart at byte 0
        send_cmd(8'hBE); read_bits(20, got);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        read_bits(4, got);
        check("R10 idle slots after abort", {28'h0, got[3:0]}, 32'hF);
        send_cmd(8'hBE); read_bits(8, got);
        check("R10 restart at byte 0", {24'h0, got[7:0]}, {24'h0, m_temp[7:0]});

        // R12 a read command ends a write after one completed byte
        send_cmd(8'h4E); send_bits(32'h000003C3, 10); model_write(32'h000003C3, 10);
        check_all("R12 read ends write");

        // R8 copy, R11 commands during busy ignored
        send_cmd(8'h4E); send_bits(32'h00409A19, 24); model_write(32'h00409A19, 24);
        send_cmd(8'h48);
        nv_th = m_th; nv_tl = m_tl; nv_res = m_res;
        send_cmd(8'h4E); send_bits(32'h00FFFFFF, 24);
        idle(WRC + 3);
        check_all("R11 write during copy ignored");
        send_cmd(8'h4E); send_bits(32'h00000000, 24); model_write(32'h00000000, 24);
        check_all("R8 scratch changed after copy");
        recall_and_check();

        // R11 during recall
        send_cmd(8'h4E); send_bits(32'h00112233, 24); model_write(32'h00112233, 24);
        send_cmd(8'hB8);
        send_cmd(8'h4E); send_bits(32'h00445566, 24);
        idle(RDC + 3);
        m_th = nv_th; m_tl = nv_tl; m_res = nv_res;
        check_all("R11 write during recall ignored");

        // Random mix of temperature loads and partial writes
        for (int it = 0; it < 16; it++) begin
            int op;
            op = int'($urandom % 3);
            if (op == 0) begin
                load_temp(16'($urandom));
                check_all("R7 R6 random temperature");
            end else begin
                logic [31:0] d;
                int n;
                d = $urandom;
                n = int'($urandom % 33);
                send_cmd(8'h4E); send_bits(d, n); model_write(d, n);
                check_all("R5 R3 random write");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule